// File: doc/BRIEF.md
# Parity-Protected Load Path with Squash and Replay

This block is the read side of a small direct-mapped data cache that guards every stored word with one even-parity bit. A load request is taken through a valid/ready handshake and looked up in the following cycle. A clean hit returns the word at once. A miss fetches the word from the next memory level, installs it and then returns it. A hit whose parity does not match is never returned. Instead the load is squashed, the line is dropped, the word is fetched again from the next level (which is trusted to hold good data), parity is generated afresh, and the load is replayed against the refilled line. The pipeline sees only a squash pulse and a later response marked as a replay. No exception is raised.

Each detected mismatch adds one to an event counter. If the replayed read also fails its parity check, the controller does not retry again. It raises a sticky fatal flag, drops the load and returns to idle. Only one load can be in flight at a time. A fault-injection input inverts the lowest data bit of a chosen stored word, so that single-bit upsets can be produced on purpose.

Top module: `parity_load_ctrl`

## Requirements
- R1: `ld_ready` is high only while no load is in flight. A load is taken on a clock edge where `ld_valid` and `ld_ready` are both high, and `ld_ready` stays low from that edge until the load has been answered or dropped.
- R2: A hit is a valid line whose stored tag equals `ld_addr[ADDR_W-1:IDX_W]` at index `ld_addr[IDX_W-1:0]`. A hit that passes parity raises `resp_valid` for one cycle, in the cycle right after the accepting edge, with the stored word, and raises no fill request.
- R3: On a miss, `fill_req` is raised with `fill_addr` set to the load address, and held with a stable address until `fill_valid`. The word on `fill_data` is installed and returned one cycle later, and a later load to that address hits.
- R4: A hit whose stored word and parity bit together have odd weight raises `squash` for one cycle instead of `resp_valid`. The line is invalidated and `fill_req` rises two cycles after `squash`. The parity check applies only to hits, so a miss never squashes.
- R5: The parity bit stored on every refill is the XOR of the 32 refilled data bits, so the refilled line reads back clean.
- R6: After a squash and its refill, the replay cycle raises `replay`, and when parity passes it raises `resp_valid` in the same cycle with the refilled word.
- R7: `err_count` increases by exactly one for each detected parity mismatch, whether in lookup or in replay, and is unchanged otherwise.
- R8: If the replayed read fails parity, `fatal_err` goes high on the next cycle and stays high until reset. That load gets no response, and the controller returns to idle and keeps serving loads.
- R9: A pulse on `fault_flip` inverts data bit 0 of the word at index `fault_idx`. Two flips cancel. A flip in the refill-write cycle applies to the newly written word.
- R10: After reset, all lines are invalid, `err_count` and `fatal_err` are zero, `ld_ready` is high, and `resp_valid`, `squash`, `replay` and `fill_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load request valid |
| ld_addr | input | ADDR_W | Word address of the load |
| ld_ready | output | 1 | Controller can take a load |
| resp_valid | output | 1 | Load data returned this cycle |
| resp_data | output | DATA_W | Returned word |
| squash | output | 1 | Load discarded after a parity mismatch |
| replay | output | 1 | Current cycle is the replay of a squashed load |
| fill_req | output | 1 | Request to the next memory level |
| fill_addr | output | ADDR_W | Address being refilled |
| fill_valid | input | 1 | Refill word present |
| fill_data | input | DATA_W | Refill word |
| fault_flip | input | 1 | Invert data bit 0 of a stored word |
| fault_idx | input | IDX_W | Line index for fault_flip |
| err_count | output | CNT_W | Parity mismatch event count |
| fatal_err | output | 1 | Sticky: replay also failed parity |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. A squash never comes with a response and is followed by a refill request two cycles later. The counter steps by one on a squash. An invalidated line reads as invalid on the next edge. A refilled word is stored with even parity. A held fill request keeps its address. A fatal flag never clears. A failed replay leads to the fatal flag. What only the bench's scenarios can show is end-to-end behaviour. A corrupted word comes back corrected after the replay. A miss on a corrupted index does not squash. Two flips cancel each other. A flip during the refill write drives the fatal path. The controller still serves loads after a fatal error. A cycle-accurate reference model compares every output on every cycle to cover all of these.

// File: rtl/plc_pkg.sv
// Shared types for the parity-protected load controller.
// Assumes: nothing beyond IEEE 1800-2017.
package plc_pkg;

    // Controller phases; order carries no meaning outside the FSM.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_INVAL,
        ST_REFILL,
        ST_REPLAY
    } plc_state_e;

endpackage

// File: rtl/plc_array.sv
// Direct-mapped storage: valid bits, tags, data words and one even-parity
// bit per word. Parity is generated from the write data on every fill.
// Assumes: at most one write and one invalidate per cycle, never to the
// same line in the same cycle; the fault flip may coincide with a write.
module plc_array #(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_par,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              flip_en,
    input  logic [IDX_W-1:0]  flip_idx
);
    localparam int LINES = 1 << IDX_W;
    localparam logic [DATA_W-1:0] FLIP_MASK = DATA_W'(1);

    logic [LINES-1:0]  vld_q;
    logic [DATA_W-1:0] data_w [LINES];
    logic [TAG_W-1:0]  tag_w  [LINES];
    logic              par_w  [LINES];

    // Valid bits: cleared on reset and invalidate, set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (inv_en) vld_q[inv_idx] <= 1'b0;
            if (wr_en)  vld_q[wr_idx]  <= 1'b1;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic              hit_wr;
        logic              hit_flip;
        logic [DATA_W-1:0] d_q;
        logic [TAG_W-1:0]  t_q;
        logic              p_q;

        assign hit_wr   = wr_en   && (wr_idx   == IDX_W'(g));
        assign hit_flip = flip_en && (flip_idx == IDX_W'(g));

        // Per-line word, tag and parity; fault flip applies after the fill.
        always_ff @(posedge clk) begin
            if (hit_wr) begin
                d_q <= wr_data ^ (hit_flip ? FLIP_MASK : '0);
                p_q <= ^wr_data;
                t_q <= wr_tag;
            end else if (hit_flip) begin
                d_q <= d_q ^ FLIP_MASK;
            end
        end

        assign data_w[g] = d_q;
        assign tag_w[g]  = t_q;
        assign par_w[g]  = p_q;
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_w[rd_idx];
    assign rd_data  = data_w[rd_idx];
    assign rd_par   = par_w[rd_idx];

    // R4: an invalidated line reads invalid after the edge.
    a_r4_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !vld_q[$past(inv_idx)]);

    // R5: an unflipped refill is stored with even overall parity.
    a_r5_fill_even: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(flip_en && flip_idx == wr_idx))
        |=> ((^data_w[$past(wr_idx)]) ^ par_w[$past(wr_idx)]) == 1'b0);

endmodule

// File: rtl/plc_fsm.sv
// Load sequencer: lookup, parity check, squash, invalidate, refill and
// replay, one load at a time. Keeps the mismatch count and fatal flag.
// Assumes: the array reads combinationally at rd_idx; the next level
// holds fill data and answers a held fill_req eventually.
module plc_fsm
    import plc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld_valid,
    input  logic [ADDR_W-1:0]       ld_addr,
    output logic                    ld_ready,
    output logic                    resp_valid,
    output logic [DATA_W-1:0]       resp_data,
    output logic                    squash,
    output logic                    replay,
    output logic                    fill_req,
    output logic [ADDR_W-1:0]       fill_addr,
    input  logic                    fill_valid,
    input  logic [DATA_W-1:0]       fill_data,
    output logic [CNT_W-1:0]        err_count,
    output logic                    fatal_err,
    output logic [IDX_W-1:0]        rd_idx,
    input  logic                    rd_valid,
    input  logic [ADDR_W-IDX_W-1:0] rd_tag,
    input  logic [DATA_W-1:0]       rd_data,
    input  logic                    rd_par,
    output logic                    wr_en,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    inv_en
);
    localparam int TAG_W = ADDR_W - IDX_W;

    plc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              retry_q;
    logic [CNT_W-1:0]  err_q;
    logic              fatal_q;
    logic              hit, par_ok, err_inc, fatal_set;

    assign rd_idx  = addr_q[IDX_W-1:0];
    assign hit     = rd_valid && (rd_tag == addr_q[ADDR_W-1:IDX_W]);
    assign par_ok  = ((^rd_data) ^ rd_par) == 1'b0;
    assign wr_tag  = TAG_W'(addr_q[ADDR_W-1:IDX_W]);
    assign wr_data = fill_data;

    assign ld_ready  = (state_q == ST_IDLE);
    assign replay    = (state_q == ST_REPLAY) && retry_q;
    assign resp_data = rd_data;
    assign fill_addr = addr_q;
    assign err_count = err_q;
    assign fatal_err = fatal_q;

    // Next phase and per-cycle strobes.
    always_comb begin
        state_d    = state_q;
        resp_valid = 1'b0;
        squash     = 1'b0;
        fill_req   = 1'b0;
        wr_en      = 1'b0;
        inv_en     = 1'b0;
        err_inc    = 1'b0;
        fatal_set  = 1'b0;
        case (state_q)
            ST_IDLE:   if (ld_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit && par_ok) begin
                    resp_valid = 1'b1;
                    state_d    = ST_IDLE;
                end else if (hit) begin
                    squash  = 1'b1;
                    err_inc = 1'b1;
                    state_d = ST_INVAL;
                end else begin
                    state_d = ST_REFILL;
                end
            end
            ST_INVAL: begin
                inv_en  = 1'b1;
                state_d = ST_REFILL;
            end
            ST_REFILL: begin
                fill_req = 1'b1;
                if (fill_valid) begin
                    wr_en   = 1'b1;
                    state_d = ST_REPLAY;
                end
            end
            ST_REPLAY: begin
                if (par_ok) begin
                    resp_valid = 1'b1;
                end else begin
                    err_inc   = 1'b1;
                    fatal_set = 1'b1;
                end
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase, captured address, replay marker, counter and fatal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            retry_q <= 1'b0;
            err_q   <= '0;
            fatal_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_valid && state_q == ST_IDLE) addr_q <= ld_addr;
            if (state_q == ST_LOOKUP) retry_q <= squash;
            if (err_inc) err_q <= err_q + CNT_W'(1);
            if (fatal_set) fatal_q <= 1'b1;
        end
    end

    // R1: a taken load closes the door until it is finished.
    a_r1_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready);

    // R4: a squashed load is not answered in the same cycle.
    a_r4_no_resp_on_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !resp_valid);

    // R4: refill follows a squash after the invalidate cycle.
    a_r4_refill_after_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> ##1 fill_req);

    // R3: a pending fill keeps its request and address.
    a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

    // R7: each squash counts exactly one event.
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (err_count == $past(err_count) + CNT_W'(1)));

    // R8: an unanswered replay ends in the fatal flag.
    a_r8_replay_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (replay && !resp_valid) |=> fatal_err);

    // R8: the fatal flag is sticky.
    a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err);

endmodule

// File: rtl/parity_load_ctrl.sv
// Top of the parity-protected load path: joins the storage array and the
// load sequencer. Stores are not handled here; the next level is trusted.
// Assumes: synchronous active-low reset held for at least one edge.
module parity_load_ctrl #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              squash,
    output logic              replay,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fault_flip,
    input  logic [IDX_W-1:0]  fault_idx,
    output logic [CNT_W-1:0]  err_count,
    output logic              fatal_err
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid, rd_par, wr_en, inv_en;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic [DATA_W-1:0] rd_data, wr_data;

    plc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .rd_par   (rd_par),
        .wr_en    (wr_en),
        .wr_idx   (rd_idx),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .inv_en   (inv_en),
        .inv_idx  (rd_idx),
        .flip_en  (fault_flip),
        .flip_idx (fault_idx)
    );

    plc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid   (ld_valid),
        .ld_addr    (ld_addr),
        .ld_ready   (ld_ready),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .squash     (squash),
        .replay     (replay),
        .fill_req   (fill_req),
        .fill_addr  (fill_addr),
        .fill_valid (fill_valid),
        .fill_data  (fill_data),
        .err_count  (err_count),
        .fatal_err  (fatal_err),
        .rd_idx     (rd_idx),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data),
        .rd_par     (rd_par),
        .wr_en      (wr_en),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data),
        .inv_en     (inv_en)
    );

endmodule

// File: tb/parity_load_ctrl_test.sv
// Bench: behavioural reference model compared every cycle, plus scenarios.
module parity_load_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int FILL_LAT   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [9:0]  ld_addr = '0;
    logic        ld_ready, resp_valid, squash, replay, fill_req, fatal_err;
    logic [31:0] resp_data;
    logic [9:0]  fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        fault_flip = 1'b0;
    logic [3:0]  fault_idx = '0;
    logic [7:0]  err_count;

    parity_load_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_ready(ld_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .squash(squash), .replay(replay), .fill_req(fill_req),
        .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_data(fill_data),
        .fault_flip(fault_flip), .fault_idx(fault_idx),
        .err_count(err_count), .fatal_err(fatal_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0, cycles = 0;
    bit started = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [9:0] a);
        return ({22'b0, a} * 32'h2545F491) + 32'h6A09E667;
    endfunction

    // ---- reference model ----
    int          m_state = 0;
    logic [9:0]  m_addr;
    bit          m_retry, m_fatal;
    int          m_err = 0;
    logic [31:0] m_data [16];
    bit          m_par [16], m_vld [16];
    logic [5:0]  m_tag [16];

    function automatic bit m_clean(input int i);
        return ((^m_data[i]) ^ m_par[i]) == 1'b0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0; m_err = 0; m_fatal = 0; m_retry = 0;
            foreach (m_vld[i]) m_vld[i] = 0;
        end else begin
            int ix;
            ix = int'(m_addr[3:0]);
            case (m_state)
                0: if (ld_valid) begin m_addr = ld_addr; m_state = 1; end
                1: begin
                    if (m_vld[ix] && m_tag[ix] == m_addr[9:4]) begin
                        if (m_clean(ix)) m_state = 0;
                        else begin m_err++; m_retry = 1; m_state = 2; end
                    end else begin m_retry = 0; m_state = 3; end
                end
                2: begin m_vld[ix] = 0; m_state = 3; end
                3: if (fill_valid) begin
                    m_data[ix] = fill_data; m_par[ix] = ^fill_data;
                    m_tag[ix] = m_addr[9:4]; m_vld[ix] = 1; m_state = 4;
                end
                default: begin
                    if (!m_clean(ix)) begin m_fatal = 1; m_err++; end
                    m_state = 0;
                end
            endcase
            if (fault_flip) m_data[int'(fault_idx)][0] = ~m_data[int'(fault_idx)][0];
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (started && rst_n) begin
            int ix;
            bit e_hit, e_resp, e_sq;
            ix = int'(m_addr[3:0]);
            e_hit = m_vld[ix] && m_tag[ix] == m_addr[9:4];
            e_resp = (m_state == 1 && e_hit && m_clean(ix)) || (m_state == 4 && m_clean(ix));
            e_sq = (m_state == 1 && e_hit && !m_clean(ix));
            check("R1 ld_ready", 32'(ld_ready), 32'(m_state == 0));
            check("R2 resp_valid", 32'(resp_valid), 32'(e_resp));
            if (e_resp) check("R2 resp_data", resp_data, m_data[ix]);
            check("R4 squash", 32'(squash), 32'(e_sq));
            check("R6 replay", 32'(replay), 32'(m_state == 4 && m_retry));
            check("R3 fill_req", 32'(fill_req), 32'(m_state == 3));
            if (m_state == 3) check("R3 fill_addr", 32'(fill_addr), 32'(m_addr));
            check("R7 err_count", 32'(err_count), 32'(m_err));
            check("R8 fatal_err", 32'(fatal_err), 32'(m_fatal));
        end
    end

    // ---- next-level memory, fault driver and response monitor ----
    int   lat_cnt = 0, fills = 0, resps = 0, squashes = 0;
    bit   inj_req = 0, flip_on_fill = 0;
    logic [3:0]  inj_idx = '0, fill_flip_idx = '0;
    logic [31:0] last_data;
    bit   last_replay;

    always @(negedge clk) begin
        fault_flip = 1'b0;
        if (fill_valid) fill_valid = 1'b0;
        else if (fill_req) begin
            if (lat_cnt == FILL_LAT - 1) begin
                fill_valid = 1'b1; fill_data = mem_word(fill_addr); lat_cnt = 0; fills++;
                if (flip_on_fill) begin
                    fault_flip = 1'b1; fault_idx = fill_flip_idx; flip_on_fill = 0;
                end
            end else lat_cnt++;
        end
        if (inj_req) begin fault_flip = 1'b1; fault_idx = inj_idx; inj_req = 0; end
        if (resp_valid) begin resps++; last_data = resp_data; last_replay = replay; end
        if (squash) squashes++;
    end

    task automatic inject(input logic [3:0] idx);
        inj_idx = idx; inj_req = 1;
        repeat (3) @(negedge clk);
    endtask

    bit first_resp, first_ready;
    task automatic do_load(input logic [9:0] a);
        while (!ld_ready) @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        @(negedge clk);
        ld_valid = 1'b0;
        first_resp = resp_valid; first_ready = ld_ready;
        for (int k = 0; k < 50 && !ld_ready; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [9:0] A = 10'h013, C = 10'h023, B = 10'h05A, D = 10'h0C7;

    initial begin
        int f0, r0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; started = 1;
        // R10: reset state
        check("R10 ld_ready", 32'(ld_ready), 1);
        check("R10 err_count", 32'(err_count), 0);
        check("R10 fatal_err", 32'(fatal_err), 0);
        check("R10 idle outputs", 32'({resp_valid, squash, replay, fill_req}), 0);

        // R3: cold miss
        f0 = fills; do_load(A);
        check("R3 miss no early resp", 32'(first_resp), 0);
        check("R1 busy after accept", 32'(first_ready), 0);
        check("R3 miss data", last_data, mem_word(A));
        check("R3 one fill", 32'(fills - f0), 1);
        // R2: hit
        f0 = fills; do_load(A);
        check("R2 hit next cycle", 32'(first_resp), 1);
        check("R2 hit data", last_data, mem_word(A));
        check("R2 no fill on hit", 32'(fills - f0), 0);
        // R3: conflict miss at same index
        f0 = fills; do_load(C);
        check("R3 conflict data", last_data, mem_word(C));
        check("R3 conflict fill", 32'(fills - f0), 1);
        // R4 R6 R7: corrupted hit replays with good data
        inject(4'h3);
        s0 = squashes; f0 = fills; do_load(C);
        check("R4 squash seen", 32'(squashes - s0), 1);
        check("R6 replay flagged", 32'(last_replay), 1);
        check("R6 replay data", last_data, mem_word(C));
        check("R7 one event", 32'(err_count), 1);
        check("R4 refetch", 32'(fills - f0), 1);
        // R5: refilled line is clean
        s0 = squashes; do_load(C);
        check("R5 clean after refill", 32'(squashes - s0), 0);
        check("R5 hit data", last_data, mem_word(C));
        // R9: double flip cancels
        inject(4'h3); inject(4'h3);
        s0 = squashes; do_load(C);
        check("R9 double flip clean", 32'(squashes - s0), 0);
        check("R9 data intact", last_data, mem_word(C));
        // R4: miss on a corrupted index does not squash
        inject(4'h3);
        s0 = squashes; do_load(A);
        check("R4 no squash on miss", 32'(squashes - s0), 0);
        check("R4 miss data", last_data, mem_word(A));
        check("R7 count unchanged", 32'(err_count), 1);
        // R8 R9: flip during refill makes replay fail
        do_load(B);
        inject(4'hA);
        fill_flip_idx = 4'hA; flip_on_fill = 1;
        r0 = resps; do_load(B);
        check("R8 no response", 32'(resps - r0), 0);
        check("R8 fatal set", 32'(fatal_err), 1);
        check("R7 two events", 32'(err_count), 3);
        // R8: still serving, flag sticky
        do_load(D);
        check("R8 serves after fatal", last_data, mem_word(D));
        check("R8 fatal sticky", 32'(fatal_err), 1);
        check("R1 idle at end", 32'(ld_ready), 1);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule